// File: doc/BRIEF.md
# PS/2 Frame Receiver with Timeout

This block turns the two-wire serial traffic from a keyboard and, optionally, a mouse into bytes for the host register block. Each device drives its own clock and data lines. The receiver samples both lines with the controller's system clock through two-flop synchronizers. It takes one bit on every falling edge of the synchronized device clock.

A frame has eleven bits: a low start bit, eight data bits least significant first, an odd parity bit and a high stop bit. A completed frame is handed over as a one-cycle pulse. The pulse carries the byte, a parity-error flag and an auxiliary tag that marks mouse traffic. A timer starts at the start bit. If the frame does not finish before the timer runs out, the receiver hands over the substitute byte 0xFF with the timeout flag set. When the inhibit input is low, completed frames are dropped instead of delivered.

Both channels share one delivery port. If both channels finish in the same cycle, the keyboard byte goes out first and the mouse byte follows in the next cycle.

Top module: `ps2_frame_rx`

## Requirements
- R1: After reset, `rx_valid_o`, `rx_timeout_o`, `rx_parity_err_o` and `rx_aux_o` are low, and no byte is delivered until a frame completes.
- R2: A frame is taken bit by bit on falling edges of the synchronized device clock, in this order: start (0), data bit 0 through data bit 7, parity, stop (1). When the frame completes, `rx_valid_o` pulses high for one cycle and `rx_byte_o` holds the eight data bits.
- R3: Parity is odd. `rx_parity_err_o` is 1 with a delivered frame exactly when the data bits and the parity bit together hold an even number of ones. The byte is still delivered in that case.
- R4: If the stop-bit edge has not arrived within `TIMEOUT_CYC` system cycles of the start-bit edge, the receiver delivers byte 0xFF with `rx_timeout_o`=1 and `rx_parity_err_o`=0. It then returns to idle and accepts the next frame normally.
- R5: A falling device-clock edge with data high, seen while idle, does not start a frame and does not shift the alignment of the frame that follows.
- R6: A frame whose stop bit is 0 is discarded without delivery, and the receiver returns to idle ready for the next frame.
- R7: While `inhibit_n_i` is low at the stop-bit edge, a completed frame (with good or bad parity) is discarded. A timeout substitute byte is still delivered.
- R8: Mouse-channel bytes are delivered with `rx_aux_o`=1 and keyboard bytes with `rx_aux_o`=0. While `ms_en_i` is low the mouse lines are ignored and nothing is delivered from them.
- R9: If both channels complete a frame in the same cycle, the keyboard byte is delivered first and the mouse byte in the next cycle. Neither is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| kbd_clk_i | input | 1 | Keyboard device clock line |
| kbd_dat_i | input | 1 | Keyboard device data line |
| ms_clk_i | input | 1 | Mouse device clock line |
| ms_dat_i | input | 1 | Mouse device data line |
| ms_en_i | input | 1 | Enables the mouse channel (PS/2 board mode) |
| inhibit_n_i | input | 1 | Low discards completed frames |
| rx_valid_o | output | 1 | One-cycle delivery strobe |
| rx_byte_o | output | 8 | Delivered byte |
| rx_aux_o | output | 1 | 1 when the byte came from the mouse channel |
| rx_parity_err_o | output | 1 | Odd-parity check failed |
| rx_timeout_o | output | 1 | Frame stalled; byte is the 0xFF substitute |

## Verification
The bench sweeps all 256 keyboard byte values, so a wrong bit order or an off-by-one shift shows up as a wrong byte. It sends frames with deliberately wrong parity, where an inverted parity sense would flag good frames and pass bad ones. It stalls a frame halfway, where a missing timer would hang or deliver nothing, and a wrong substitute value would fail the 0xFF check. It then sends a stray idle edge, a frame with a low stop bit, inhibited frames, a disabled mouse channel and two frames that finish in the same cycle, each followed by a clean frame. A receiver that lost alignment, leaked an inhibited byte or dropped the colliding mouse byte would fail these checks.

// File: rtl/ps2rx_pkg.sv
package ps2rx_pkg;

  localparam int unsigned FRAME_BITS = 11;
  localparam int unsigned DATA_BITS  = 8;
  localparam int unsigned BCNT_W     = $clog2(FRAME_BITS + 1);
  localparam logic [BCNT_W-1:0] PAR_POS  = BCNT_W'(DATA_BITS + 1);
  localparam logic [BCNT_W-1:0] STOP_POS = BCNT_W'(DATA_BITS + 2);
  localparam logic [DATA_BITS-1:0] TMO_BYTE = '1;

  typedef enum logic {RX_IDLE = 1'b0, RX_BUSY = 1'b1} rx_state_e;

  typedef struct packed {
    logic                 v;
    logic [DATA_BITS-1:0] byte_q;
    logic                 perr;
    logic                 tmo;
  } rx_evt_t;

  // Odd parity: the data bits plus the parity bit must hold an odd count of ones.
  function automatic logic parity_bad(input logic [DATA_BITS-1:0] d, input logic p);
    return ~(^{d, p});
  endfunction

  // LSB-first shift: new bit enters at the top and moves down.
  function automatic logic [DATA_BITS-1:0] shift_in(input logic [DATA_BITS-1:0] sh,
                                                    input logic b);
    return {b, sh[DATA_BITS-1:1]};
  endfunction

  function automatic logic is_data_pos(input logic [BCNT_W-1:0] n);
    return (n >= BCNT_W'(1)) && (n <= BCNT_W'(DATA_BITS));
  endfunction

endpackage

// File: rtl/ps2rx_sync.sv
module ps2rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_clk_i,
  input  logic line_dat_i,
  output logic fall_o,
  output logic dat_o
);
  logic [STAGES-1:0] clk_sr;
  logic [STAGES-1:0] dat_sr;
  logic              clk_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_sr   <= '1;
      dat_sr   <= '1;
      clk_prev <= 1'b1;
    end else begin
      clk_sr   <= {clk_sr[STAGES-2:0], line_clk_i};
      dat_sr   <= {dat_sr[STAGES-2:0], line_dat_i};
      clk_prev <= clk_sr[STAGES-1];
    end
  end

  assign fall_o = clk_prev & ~clk_sr[STAGES-1];
  assign dat_o  = dat_sr[STAGES-1];

endmodule

// File: rtl/ps2rx_timer.sv
module ps2rx_timer #(
  parameter int unsigned LIMIT = 600
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic run_i,
  output logic expire_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt <= '0;
    else if (start_i)              cnt <= '0;
    else if (run_i && cnt != LAST) cnt <= cnt + CW'(1);
  end

  assign expire_o = run_i && (cnt == LAST);

  assert_timer_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);

endmodule

// File: rtl/ps2rx_chan.sv
module ps2rx_chan
  import ps2rx_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC = 600
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    en_i,
  input  logic    inhibit_n_i,
  input  logic    line_clk_i,
  input  logic    line_dat_i,
  output rx_evt_t evt_o
);
  logic             fall, sdat;
  rx_state_e        st;
  logic [BCNT_W-1:0] bcnt;
  logic [DATA_BITS-1:0] sh;
  logic             par_q;
  logic             tmo_expire;

  // named internal events
  logic start_evt, stop_evt, frame_ok, frame_drop, tmo_evt;

  ps2rx_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .line_clk_i(line_clk_i), .line_dat_i(line_dat_i),
    .fall_o(fall), .dat_o(sdat)
  );

  assign start_evt  = en_i && (st == RX_IDLE) && fall && !sdat;
  assign stop_evt   = en_i && (st == RX_BUSY) && fall && (bcnt == STOP_POS);
  assign tmo_evt    = en_i && tmo_expire && !stop_evt;
  assign frame_ok   = stop_evt && sdat && inhibit_n_i;
  assign frame_drop = stop_evt && !frame_ok;

  ps2rx_timer #(.LIMIT(TIMEOUT_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n),
    .start_i(start_evt), .run_i(en_i && (st == RX_BUSY)),
    .expire_o(tmo_expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= RX_IDLE;
      bcnt  <= '0;
      sh    <= '0;
      par_q <= 1'b0;
    end else if (!en_i) begin
      st   <= RX_IDLE;
      bcnt <= '0;
    end else if (start_evt) begin
      st   <= RX_BUSY;
      bcnt <= BCNT_W'(1);
    end else if (st == RX_BUSY) begin
      if (tmo_evt || stop_evt) begin
        st   <= RX_IDLE;
        bcnt <= '0;
      end else if (fall) begin
        if (is_data_pos(bcnt)) sh <= shift_in(sh, sdat);
        if (bcnt == PAR_POS)   par_q <= sdat;
        bcnt <= bcnt + BCNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_o <= '0;
    end else begin
      evt_o.v <= 1'b0;
      if (frame_ok) begin
        evt_o.v      <= 1'b1;
        evt_o.byte_q <= sh;
        evt_o.perr   <= parity_bad(sh, par_q);
        evt_o.tmo    <= 1'b0;
      end else if (tmo_evt) begin
        evt_o.v      <= 1'b1;
        evt_o.byte_q <= TMO_BYTE;
        evt_o.perr   <= 1'b0;
        evt_o.tmo    <= 1'b1;
      end
    end
  end

  assert_bitcnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == RX_BUSY) |-> (bcnt >= BCNT_W'(1) && bcnt <= STOP_POS));

  assert_timeout_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_o.v && evt_o.tmo) |-> (evt_o.byte_q == TMO_BYTE && !evt_o.perr));

  assert_inhibit_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_o.v && !evt_o.tmo) |-> $past(inhibit_n_i));

  assert_disabled_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (st == RX_IDLE && !evt_o.v));

  assert_drop_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_drop |=> !evt_o.v);

endmodule

// File: rtl/ps2rx_merge.sv
module ps2rx_merge
  import ps2rx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  rx_evt_t              kb_i,
  input  rx_evt_t              ms_i,
  output logic                 valid_o,
  output logic [DATA_BITS-1:0] byte_o,
  output logic                 aux_o,
  output logic                 perr_o,
  output logic                 tmo_o
);
  rx_evt_t pend;
  logic    collide;

  assign collide = kb_i.v && ms_i.v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend    <= '0;
      valid_o <= 1'b0;
      byte_o  <= '0;
      aux_o   <= 1'b0;
      perr_o  <= 1'b0;
      tmo_o   <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (kb_i.v) begin
        valid_o <= 1'b1;
        byte_o  <= kb_i.byte_q;
        perr_o  <= kb_i.perr;
        tmo_o   <= kb_i.tmo;
        aux_o   <= 1'b0;
        if (collide) pend <= ms_i;
      end else if (pend.v) begin
        valid_o <= 1'b1;
        byte_o  <= pend.byte_q;
        perr_o  <= pend.perr;
        tmo_o   <= pend.tmo;
        aux_o   <= 1'b1;
        pend.v  <= 1'b0;
      end else if (ms_i.v) begin
        valid_o <= 1'b1;
        byte_o  <= ms_i.byte_q;
        perr_o  <= ms_i.perr;
        tmo_o   <= ms_i.tmo;
        aux_o   <= 1'b1;
      end
    end
  end

  assert_no_pend_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(pend.v && ms_i.v));

  assert_pend_drains_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pend.v && !kb_i.v) |=> (valid_o && aux_o));

  assert_kb_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
    collide |=> (valid_o && !aux_o));

endmodule

// File: rtl/ps2_frame_rx.sv
module ps2_frame_rx
  import ps2rx_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC = 600
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       kbd_clk_i,
  input  logic       kbd_dat_i,
  input  logic       ms_clk_i,
  input  logic       ms_dat_i,
  input  logic       ms_en_i,
  input  logic       inhibit_n_i,
  output logic       rx_valid_o,
  output logic [7:0] rx_byte_o,
  output logic       rx_aux_o,
  output logic       rx_parity_err_o,
  output logic       rx_timeout_o
);
  localparam int unsigned NCH = 2;

  logic    [NCH-1:0] ch_en, ch_clk, ch_dat;
  rx_evt_t           ch_evt [NCH];

  assign ch_en  = {ms_en_i, 1'b1};
  assign ch_clk = {ms_clk_i, kbd_clk_i};
  assign ch_dat = {ms_dat_i, kbd_dat_i};

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    ps2rx_chan #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_chan (
      .clk(clk), .rst_n(rst_n),
      .en_i(ch_en[g]), .inhibit_n_i(inhibit_n_i),
      .line_clk_i(ch_clk[g]), .line_dat_i(ch_dat[g]),
      .evt_o(ch_evt[g])
    );
  end

  ps2rx_merge u_merge (
    .clk(clk), .rst_n(rst_n),
    .kb_i(ch_evt[0]), .ms_i(ch_evt[1]),
    .valid_o(rx_valid_o), .byte_o(rx_byte_o), .aux_o(rx_aux_o),
    .perr_o(rx_parity_err_o), .tmo_o(rx_timeout_o)
  );

  assert_tmo_ff_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid_o && rx_timeout_o) |-> (rx_byte_o == 8'hFF));

  assert_aux_needs_mouse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid_o && rx_aux_o) |-> $past(ms_en_i));

endmodule

// File: tb/ps2_frame_rx_test.sv
module ps2_frame_rx_test;
  localparam int TMO  = 600;
  localparam int HALF = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic kc = 1'b1, kd = 1'b1, mc = 1'b1, md = 1'b1;
  logic ms_en = 1'b1, inh_n = 1'b1;
  logic       rx_valid, rx_aux, rx_perr, rx_to;
  logic [7:0] rx_byte;

  int checks = 0, fails = 0;
  int mon_n = 0;
  logic [7:0] m_byte [4];
  logic       m_aux [4], m_perr [4], m_to [4];

  always #5 clk = ~clk;

  ps2_frame_rx #(.TIMEOUT_CYC(TMO)) uut (
    .clk(clk), .rst_n(rst_n),
    .kbd_clk_i(kc), .kbd_dat_i(kd), .ms_clk_i(mc), .ms_dat_i(md),
    .ms_en_i(ms_en), .inhibit_n_i(inh_n),
    .rx_valid_o(rx_valid), .rx_byte_o(rx_byte), .rx_aux_o(rx_aux),
    .rx_parity_err_o(rx_perr), .rx_timeout_o(rx_to)
  );

  always @(negedge clk) begin
    if (rst_n && rx_valid) begin
      if (mon_n < 4) begin
        m_byte[mon_n] = rx_byte;
        m_aux[mon_n]  = rx_aux;
        m_perr[mon_n] = rx_perr;
        m_to[mon_n]   = rx_to;
      end
      mon_n = mon_n + 1;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic odd_par(input logic [7:0] d);
    int ones = 0;
    for (int i = 0; i < 8; i++) ones += d[i];
    return (ones % 2 == 0) ? 1'b1 : 1'b0;
  endfunction

  // mask bit0 = keyboard lines, bit1 = mouse lines
  task automatic send(input int mask, input logic st, input logic [7:0] d,
                      input logic p, input logic sp, input int nbits);
    logic [10:0] f;
    f = {sp, p, d, st};
    for (int i = 0; i < nbits; i++) begin
      if (mask[0]) kd = f[i];
      if (mask[1]) md = f[i];
      repeat (HALF) @(posedge clk);
      if (mask[0]) kc = 1'b0;
      if (mask[1]) mc = 1'b0;
      repeat (HALF) @(posedge clk);
      if (mask[0]) kc = 1'b1;
      if (mask[1]) mc = 1'b1;
    end
    kd = 1'b1; md = 1'b1;
    repeat (30) @(posedge clk);
  endtask

  task automatic good(input int mask, input logic [7:0] d);
    send(mask, 1'b0, d, odd_par(d), 1'b1, 11);
  endtask

  task automatic expect_one(input string req, input logic [7:0] d, input logic aux,
                            input logic perr, input logic to);
    check(req, mon_n, 1);
    if (mon_n >= 1) begin
      check(req, int'(m_byte[0]), int'(d));
      check(req, int'(m_aux[0]),  int'(aux));
      check(req, int'(m_perr[0]), int'(perr));
      check(req, int'(m_to[0]),   int'(to));
    end
    mon_n = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R1 valid", int'(rx_valid), 0);
    check("R1 timeout", int'(rx_to), 0);
    check("R1 perr", int'(rx_perr), 0);
    check("R1 aux", int'(rx_aux), 0);
    rst_n = 1'b1;
    repeat (50) @(posedge clk);
    check("R1 idle", mon_n, 0);

    // R2: exhaustive keyboard sweep, aux tag 0 (R8)
    for (int v = 0; v < 256; v++) begin
      mon_n = 0;
      good(1, v[7:0]);
      expect_one("R2 sweep", v[7:0], 1'b0, 1'b0, 1'b0);
    end

    // R3: wrong parity, byte still delivered
    begin
      logic [7:0] pv [4] = '{8'h00, 8'hA5, 8'hFF, 8'h3C};
      for (int i = 0; i < 4; i++) begin
        send(1, 1'b0, pv[i], ~odd_par(pv[i]), 1'b1, 11);
        expect_one("R3 parity", pv[i], 1'b0, 1'b1, 1'b0);
      end
    end

    // R4: stall after 4 bits
    send(1, 1'b0, 8'h12, 1'b0, 1'b1, 4);
    repeat (TMO + 50) @(posedge clk);
    expect_one("R4 timeout", 8'hFF, 1'b0, 1'b0, 1'b1);
    good(1, 8'h5A);
    expect_one("R4 recover", 8'h5A, 1'b0, 1'b0, 1'b0);

    // R5: lone edge with data high while idle
    send(1, 1'b1, 8'h00, 1'b0, 1'b1, 1);
    check("R5 no start", mon_n, 0);
    good(1, 8'hC3);
    expect_one("R5 align", 8'hC3, 1'b0, 1'b0, 1'b0);

    // R6: low stop bit
    send(1, 1'b0, 8'h81, odd_par(8'h81), 1'b0, 11);
    check("R6 dropped", mon_n, 0);
    good(1, 8'h7E);
    expect_one("R6 recover", 8'h7E, 1'b0, 1'b0, 1'b0);

    // R7: inhibit
    inh_n = 1'b0;
    good(1, 8'h1C);
    check("R7 good dropped", mon_n, 0);
    send(1, 1'b0, 8'h1C, ~odd_par(8'h1C), 1'b1, 11);
    check("R7 bad dropped", mon_n, 0);
    send(1, 1'b0, 8'h00, 1'b0, 1'b1, 3);
    repeat (TMO + 50) @(posedge clk);
    expect_one("R7 timeout kept", 8'hFF, 1'b0, 1'b0, 1'b1);
    inh_n = 1'b1;
    good(1, 8'h29);
    expect_one("R7 release", 8'h29, 1'b0, 1'b0, 1'b0);

    // R8: mouse channel
    good(2, 8'hF0);
    expect_one("R8 mouse", 8'hF0, 1'b1, 1'b0, 1'b0);
    send(2, 1'b0, 8'h08, ~odd_par(8'h08), 1'b1, 11);
    expect_one("R8 mouse perr", 8'h08, 1'b1, 1'b1, 1'b0);
    ms_en = 1'b0;
    good(2, 8'h44);
    check("R8 mouse disabled", mon_n, 0);
    ms_en = 1'b1;
    repeat (5) @(posedge clk);
    good(2, 8'h99);
    expect_one("R8 mouse reenabled", 8'h99, 1'b1, 1'b0, 1'b0);

    // R9: both channels complete in the same cycle
    good(3, 8'h6D);
    check("R9 count", mon_n, 2);
    check("R9 first aux", int'(m_aux[0]), 0);
    check("R9 second aux", int'(m_aux[1]), 1);
    check("R9 first byte", int'(m_byte[0]), 8'h6D);
    check("R9 second byte", int'(m_byte[1]), 8'h6D);
    mon_n = 0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule